// File: doc/BRIEF.md
# FIFO Threshold Offset Programmer

This block supplies the two threshold offsets a FIFO uses for its programmable level flags: the empty-side offset, which sets how close to empty the FIFO may get before its near-empty flag asserts, and the full-side offset, which does the same for the full side. When reset is released, the block picks one of four programming methods from two shared configuration pins. Two of the methods are fixed presets. One takes the offsets from two write-port transfers. The last shifts in a 22-bit serial stream, one bit per write-clock edge, while an active-low enable is held.

The same two pins do a second job after reset. In serial mode, one of them is the active-low shift enable and the other carries the data bit. The `load_done` output stays low until the chosen method has finished. The surrounding FIFO uses it to keep its write side closed until the offsets are valid. The FIFO storage and the flag comparators sit outside this block.

Top module: `fifo_offset_loader`

## Requirements
- R1: The method is the value of {cfg1_shen_n, cfg0_sbit} on the last rising clock edge that sees rst_n low. The codes are 2'b00 parallel load, 2'b01 preset 8, 2'b10 preset 16 and 2'b11 serial load. Pin changes after reset do not change the method or, in preset mode, the offsets.
- R2: While rst_n is low, load_done is 0. In serial mode both offsets read 0 during reset.
- R3: With preset code 2'b01, both offsets read 8, and load_done is 1 from the first rising edge after rst_n goes high.
- R4: With preset code 2'b10, both offsets read 16, and load_done is 1 from the first rising edge after rst_n goes high.
- R5: In serial mode, a rising edge with cfg1_shen_n low shifts in the bit on cfg0_sbit. An edge with cfg1_shen_n high leaves the offsets unchanged.
- R6: The serial stream is 22 bits. Bit 1 is the full-side offset MSB, bit 11 is its LSB, bit 12 is the empty-side offset MSB and bit 22 is its LSB.
- R7: In serial mode, load_done stays 0 after 21 bits and becomes 1 on the edge that shifts the 22nd bit. Later shift edges change nothing.
- R8: In parallel mode, the first edge with wr_req high loads full_ofs from wr_data. The second such edge loads empty_ofs and sets load_done. Edges with wr_req low are ignored.
- R9: In parallel mode, writes after load_done is set leave both offsets unchanged.
- R10: Once set, load_done stays 1 until the next reset. A new reset selects the method again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Synchronous active-low reset; the method is captured while it is low |
| cfg1_shen_n | input | 1 | Method select bit 1 during reset; active-low serial shift enable afterwards |
| cfg0_sbit | input | 1 | Method select bit 0 during reset; serial data bit afterwards |
| wr_req | input | 1 | Enabled write-port transfer strobe |
| wr_data | input | OFS_W | Low field of the write-port data bus |
| empty_ofs | output | OFS_W | Empty-side threshold offset |
| full_ofs | output | OFS_W | Full-side threshold offset |
| load_done | output | 1 | Offsets valid; writes to the FIFO may start |

## Verification
Some properties are checked on every clock cycle:
- the method stays fixed outside reset;
- the shift register holds on edges where the enable is inactive;
- the parallel registers hold when no write is presented;
- both programmed values freeze once loading is complete;
- the done flag never falls outside reset;
- at most one loading method ever reports completion.

Other behaviour can only be shown by the bench's scenarios, because it depends on the order and values of the stimulus:
- the bit order of the serial stream;
- the exact edge on which loading completes;
- the preset values;
- that pin activity after reset leaves a preset untouched.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

   typedef enum logic [1:0] {
      LOAD_PAR   = 2'b00,
      LOAD_PRE_A = 2'b01,
      LOAD_PRE_B = 2'b10,
      LOAD_SER   = 2'b11
   } load_mode_e;

   function automatic load_mode_e decode_mode(input logic sel1, input logic sel0);
      return load_mode_e'({sel1, sel0});
   endfunction

endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch
   import ofs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel1,
   input  logic       sel0,
   output load_mode_e mode
);

   load_mode_e mode_q;

   // Track the pins on every reset edge; the last one before release wins
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= decode_mode(sel1, sel0);
   end

   assign mode = mode_q;

   // R1: method is frozen outside reset
   assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(mode_q));

endmodule

// File: rtl/ofs_serial_shift.sv
module ofs_serial_shift #(
   parameter int OFS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             shen_n,
   input  logic             sbit,
   output logic [OFS_W-1:0] y_ofs,
   output logic [OFS_W-1:0] x_ofs,
   output logic             done
);

   localparam int SER_BITS = 2 * OFS_W;
   localparam int CNT_W    = $clog2(SER_BITS + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SER_BITS - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SER_BITS);

   logic [SER_BITS-1:0] sr_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                done_q;
   logic                shift_en;

   assign shift_en = active && !done_q && !shen_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q   <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (shift_en) begin
         sr_q  <= {sr_q[SER_BITS-2:0], sbit};
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST_CNT)
            done_q <= 1'b1;
      end
   end

   // First bit ends up at the top of the full-side field
   assign y_ofs = sr_q[SER_BITS-1:OFS_W];
   assign x_ofs = sr_q[OFS_W-1:0];
   assign done  = done_q;

   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);
   assert_done_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (cnt_q == FULL_CNT));
   assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      shen_n |=> $stable(sr_q));
   assert_freeze_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> ($stable(sr_q) && $stable(cnt_q)));

endmodule

// File: rtl/ofs_parallel_cap.sv
module ofs_parallel_cap #(
   parameter int OFS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             wr_req,
   input  logic [OFS_W-1:0] wr_data,
   output logic [OFS_W-1:0] y_ofs,
   output logic [OFS_W-1:0] x_ofs,
   output logic             done
);

   logic [OFS_W-1:0] y_q, x_q;
   logic             second_q;
   logic             done_q;
   logic             take;

   assign take = active && wr_req && !done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_q      <= '0;
         x_q      <= '0;
         second_q <= 1'b0;
         done_q   <= 1'b0;
      end else if (take) begin
         if (!second_q) begin
            y_q      <= wr_data;
            second_q <= 1'b1;
         end else begin
            x_q    <= wr_data;
            done_q <= 1'b1;
         end
      end
   end

   assign y_ofs = y_q;
   assign x_ofs = x_q;
   assign done  = done_q;

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> ($stable(y_q) && $stable(x_q)));
   assert_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> second_q);
   assert_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> ($stable(y_q) && $stable(x_q)));

endmodule

// File: rtl/fifo_offset_loader.sv
module fifo_offset_loader
   import ofs_pkg::*;
#(
   parameter int OFS_W    = 11,
   parameter int PRESET_A = 8,
   parameter int PRESET_B = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg1_shen_n,
   input  logic             cfg0_sbit,
   input  logic             wr_req,
   input  logic [OFS_W-1:0] wr_data,
   output logic [OFS_W-1:0] empty_ofs,
   output logic [OFS_W-1:0] full_ofs,
   output logic             load_done
);

   localparam logic [OFS_W-1:0] PRE_A_V = OFS_W'(PRESET_A);
   localparam logic [OFS_W-1:0] PRE_B_V = OFS_W'(PRESET_B);

   generate
      if (OFS_W < 2)
         $error("OFS_W must be at least 2");
      if (PRESET_A < 0 || PRESET_A >= (1 << OFS_W))
         $error("PRESET_A does not fit in OFS_W bits");
      if (PRESET_B < 0 || PRESET_B >= (1 << OFS_W))
         $error("PRESET_B does not fit in OFS_W bits");
   endgenerate

   load_mode_e       mode;
   logic [OFS_W-1:0] ser_y, ser_x, par_y, par_x;
   logic             ser_done, par_done;
   logic             pre_done_q;
   logic             is_preset;

   ofs_mode_latch u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .sel1  (cfg1_shen_n),
      .sel0  (cfg0_sbit),
      .mode  (mode)
   );

   ofs_serial_shift #(.OFS_W(OFS_W)) u_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (mode == LOAD_SER),
      .shen_n (cfg1_shen_n),
      .sbit   (cfg0_sbit),
      .y_ofs  (ser_y),
      .x_ofs  (ser_x),
      .done   (ser_done)
   );

   ofs_parallel_cap #(.OFS_W(OFS_W)) u_par (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (mode == LOAD_PAR),
      .wr_req  (wr_req),
      .wr_data (wr_data),
      .y_ofs   (par_y),
      .x_ofs   (par_x),
      .done    (par_done)
   );

   assign is_preset = (mode == LOAD_PRE_A) || (mode == LOAD_PRE_B);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pre_done_q <= 1'b0;
      else if (is_preset)
         pre_done_q <= 1'b1;
   end

   always_comb begin
      unique case (mode)
         LOAD_PRE_A: begin
            full_ofs  = PRE_A_V;
            empty_ofs = PRE_A_V;
            load_done = pre_done_q;
         end
         LOAD_PRE_B: begin
            full_ofs  = PRE_B_V;
            empty_ofs = PRE_B_V;
            load_done = pre_done_q;
         end
         LOAD_SER: begin
            full_ofs  = ser_y;
            empty_ofs = ser_x;
            load_done = ser_done;
         end
         default: begin
            full_ofs  = par_y;
            empty_ofs = par_x;
            load_done = par_done;
         end
      endcase
   end

   assert_single_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pre_done_q, ser_done, par_done}));
   assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);
   assert_serial_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(load_done) && mode == LOAD_SER) |-> $past(!cfg1_shen_n));

endmodule

// File: tb/fifo_offset_loader_test.sv
`timescale 1ns/1ps
module fifo_offset_loader_test;

   localparam int OFS_W = 11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg1_shen_n = 1'b1;
   logic             cfg0_sbit = 1'b1;
   logic             wr_req = 1'b0;
   logic [OFS_W-1:0] wr_data = '0;
   logic [OFS_W-1:0] empty_ofs, full_ofs;
   logic             load_done;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   fifo_offset_loader #(.OFS_W(OFS_W)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg1_shen_n (cfg1_shen_n),
      .cfg0_sbit   (cfg0_sbit),
      .wr_req      (wr_req),
      .wr_data     (wr_data),
      .empty_ofs   (empty_ofs),
      .full_ofs    (full_ofs),
      .load_done   (load_done)
   );

   // entry: {serial?, full-side value, empty-side value}
   localparam logic [22:0] VEC [0:5] = '{
      {1'b1, 11'd1023, 11'd0},
      {1'b1, 11'h555,  11'h2AA},
      {1'b1, 11'd1,    11'd2047},
      {1'b0, 11'd300,  11'd45},
      {1'b0, 11'h7FF,  11'h400},
      {1'b1, 11'd1234, 11'd77}
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic enter_reset(input logic s1, input logic s0);
      @(negedge clk);
      rst_n = 1'b0; cfg1_shen_n = s1; cfg0_sbit = s0; wr_req = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic release_reset();
      rst_n = 1'b1; cfg1_shen_n = 1'b1; cfg0_sbit = 1'b0;
      @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      cfg1_shen_n = 1'b0; cfg0_sbit = b;
      @(negedge clk);
      cfg1_shen_n = 1'b1; cfg0_sbit = ~b;
   endtask

   task automatic idle_edge();
      @(negedge clk);
   endtask

   task automatic par_write(input logic [OFS_W-1:0] d);
      wr_req = 1'b1; wr_data = d;
      @(negedge clk);
      wr_req = 1'b0; wr_data = ~d;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R2: reset state in serial mode
      enter_reset(1'b1, 1'b1);
      check("R2", "done in reset", load_done, 0);
      check("R2", "full in reset", full_ofs, 0);
      check("R2", "empty in reset", empty_ofs, 0);
      release_reset();

      // Table walk: serial (R5, R6, R7) and parallel (R8) loads
      for (int v = 0; v < 6; v++) begin
         logic [21:0] val;
         val = VEC[v][21:0];
         if (VEC[v][22]) begin
            enter_reset(1'b1, 1'b1);
            release_reset();
            for (int k = 0; k < 22; k++) begin
               shift_bit(val[21-k]);
               if (k % 5 == 2) idle_edge();  // R5: disabled edges
            end
            check("R6", "serial full_ofs", full_ofs, int'(val[21:11]));
            check("R6", "serial empty_ofs", empty_ofs, int'(val[10:0]));
            check("R7", "serial done", load_done, 1);
         end else begin
            enter_reset(1'b0, 1'b0);
            release_reset();
            wr_data = 11'h3C3; idle_edge();   // R8: no strobe, ignored
            par_write(val[21:11]);
            idle_edge();
            par_write(val[10:0]);
            check("R8", "parallel full_ofs", full_ofs, int'(val[21:11]));
            check("R8", "parallel empty_ofs", empty_ofs, int'(val[10:0]));
            check("R8", "parallel done", load_done, 1);
         end
      end

      // R3: preset 8, done on first edge after release
      enter_reset(1'b0, 1'b1);
      check("R2", "done low in preset reset", load_done, 0);
      release_reset();
      check("R3", "preset A done", load_done, 1);
      check("R3", "preset A full", full_ofs, 8);
      check("R3", "preset A empty", empty_ofs, 8);

      // R4: preset 16, then pin activity after reset (R1)
      enter_reset(1'b1, 1'b0);
      release_reset();
      check("R4", "preset B full", full_ofs, 16);
      check("R4", "preset B empty", empty_ofs, 16);
      check("R4", "preset B done", load_done, 1);
      for (int k = 0; k < 8; k++) shift_bit(1'b1);
      check("R1", "preset full after pin activity", full_ofs, 16);
      check("R1", "preset empty after pin activity", empty_ofs, 16);

      // R5/R7: serial boundary at 21 and 22 bits, then extra shifts
      enter_reset(1'b1, 1'b1);
      release_reset();
      for (int k = 0; k < 21; k++) shift_bit(k[0]);
      check("R7", "done after 21 bits", load_done, 0);
      begin
         logic [OFS_W-1:0] f0, e0;
         f0 = full_ofs; e0 = empty_ofs;
         cfg0_sbit = 1'b1; repeat (3) idle_edge();
         check("R5", "full stable while disabled", full_ofs, f0);
         check("R5", "empty stable while disabled", empty_ofs, e0);
      end
      shift_bit(1'b1);
      check("R7", "done after 22 bits", load_done, 1);
      // bits 0,1,0,1,... for k=0..20 then 1: full = 01010101010
      check("R6", "alternating full_ofs", full_ofs, 11'b01010101010);
      check("R6", "alternating empty_ofs", empty_ofs, 11'b10101010101);
      for (int k = 0; k < 4; k++) shift_bit(1'b0);
      check("R7", "full after extra shifts", full_ofs, 11'b01010101010);
      check("R7", "empty after extra shifts", empty_ofs, 11'b10101010101);

      // R8/R9: parallel partial state and writes after completion
      enter_reset(1'b0, 1'b0);
      release_reset();
      par_write(11'd99);
      check("R8", "full after first write", full_ofs, 99);
      check("R8", "done after first write", load_done, 0);
      par_write(11'd7);
      check("R8", "empty after second write", empty_ofs, 7);
      par_write(11'd500);
      par_write(11'd600);
      check("R9", "full after late writes", full_ofs, 99);
      check("R9", "empty after late writes", empty_ofs, 7);

      // R10: done sticky, cleared by a new reset, method re-selected
      repeat (10) idle_edge();
      check("R10", "done still high", load_done, 1);
      enter_reset(1'b0, 1'b1);
      check("R10", "done low in new reset", load_done, 0);
      release_reset();
      check("R10", "re-selected preset", full_ofs, 8);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule